// File: doc/BRIEF.md
# Timer Channel Polarity and Capture Front End

This block sits between one timer channel's pin and the timer core. When the channel is an input, it watches an already synchronized input signal. A two-bit polarity code chooses which transitions count as events: rising, falling or both. The same code decides whether the level handed on to gated or encoder logic is inverted. On every qualifying transition it emits a one-cycle event pulse. If capture is enabled, it also stores the free-running counter value, raises a capture flag, and raises an overcapture flag when the previous capture was not yet acknowledged.

When the channel is an output, the same control bits take on a new meaning. They become an output polarity and an output enable. A registered pin value and pin enable are produced from the core's reference waveform. A configuration error flag reports any code that must not be used in the current mode.

Top module: `timer_chan_frontend`

## Requirements
- R1: Input mode, polarity code {pol_np,pol_p}=00: `edge_evt` is 1 only when `tin` is 1 and the previous-cycle sample was 0, and `lvl_out` equals `tin`.
- R2: Input mode, code 01: `edge_evt` is 1 only when `tin` is 0 and the previous sample was 1, and `lvl_out` equals the inverse of `tin`.
- R3: Input mode, code 11 with `encoder_mode`=0: `edge_evt` is 1 on any change of `tin`, `lvl_out` equals `tin`, and `cfg_err` is 0.
- R4: Input mode, code 10 is reserved. It behaves like code 00 (rising, uninverted) and drives `cfg_err` to 1.
- R5: Input mode, code 11 with `encoder_mode`=1 is illegal. It detects rising transitions only, passes the level uninverted and drives `cfg_err` to 1.
- R6: When `chan_en`=1, a qualifying transition loads `cnt_val` into `cap_val` on the clock edge where `edge_evt` is high. When `chan_en`=0, `cap_val` keeps its value, while `edge_evt` still pulses.
- R7: `cap_flag` is set by each capture and cleared by `flag_clr`. A capture in the same cycle as `flag_clr` wins and leaves the flag set.
- R8: A capture while `cap_flag` is already 1 and `flag_clr` is 0 sets `ovr_flag`. `ovr_flag` stays set until `flag_clr`.
- R9: In output mode with `chan_en`=0, or in input mode, `pin_oe` and `pin_val` are 0 one clock after the setting is applied.
- R10: In output mode with `chan_en`=1, one clock later `pin_oe`=1 and `pin_val` equals `oc_ref` XOR `pol_p`. So `pol_p`=0 gives active-high output and `pol_p`=1 gives active-low output.
- R11: In output mode, `pol_np`=1 drives `cfg_err` to 1 and has no effect on `pin_val` or `pin_oe`. With `pol_np`=0, `cfg_err` is 0.
- R12: Synchronous reset clears `cap_val`, both flags, the previous sample, `pin_val` and `pin_oe`. In output mode, `edge_evt` and `lvl_out` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_out | input | 1 | 1 = output mode, 0 = input mode |
| pol_p | input | 1 | Polarity bit P |
| pol_np | input | 1 | Polarity bit NP |
| chan_en | input | 1 | Capture enable (input) / output enable (output) |
| encoder_mode | input | 1 | Encoder use of the level is active |
| tin | input | 1 | Synchronized channel input |
| cnt_val | input | CNT_W | Free-running counter value |
| oc_ref | input | 1 | Output reference waveform |
| flag_clr | input | 1 | Clear strobe for both flags |
| edge_evt | output | 1 | One-cycle qualifying transition pulse |
| lvl_out | output | 1 | Polarity-adjusted input level |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Capture occurred |
| ovr_flag | output | 1 | Capture while flag still set |
| pin_val | output | 1 | Output pin value |
| pin_oe | output | 1 | Output pin enable |
| cfg_err | output | 1 | Illegal control code for the current mode |

## Verification
`edge_evt`, `lvl_out` and `cfg_err` are combinational from the inputs and the previous-sample register. The bench therefore checks them one time unit after it drives inputs at the falling edge, before the next rising edge. `cap_val`, both flags, `pin_val` and `pin_oe` settle one rising edge after the stimulus, so they are checked at the following falling edge. The bench model advances its expected state at that same rising edge. The sweep covers every mode, code, encoder, enable and reference setting, with each input transition pair and periodic flag clears.

// File: rtl/chanfe_pkg.sv
package chanfe_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_mode_e;

    typedef struct packed {
        edge_mode_e mode;
        logic       invert;
        logic       bad_code;
    } edge_cfg_t;

    function automatic edge_cfg_t decode_edge(input logic np, input logic p, input logic enc);
        edge_cfg_t c;
        c.mode     = EDGE_RISE;
        c.invert   = 1'b0;
        c.bad_code = 1'b0;
        unique case ({np, p})
            2'b00: ;
            2'b01: begin
                c.mode   = EDGE_FALL;
                c.invert = 1'b1;
            end
            2'b10: c.bad_code = 1'b1;
            2'b11: begin
                if (enc) c.bad_code = 1'b1;
                else     c.mode     = EDGE_BOTH;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/chanfe_edge_qual.sv
module chanfe_edge_qual
    import chanfe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_mode,
    input  logic pol_p,
    input  logic pol_np,
    input  logic encoder_mode,
    input  logic tin,
    output logic edge_evt,
    output logic lvl_out,
    output logic code_err
);

    edge_cfg_t cfg;
    logic      prev_d, prev_q;
    logic      rise, fall;

    always_comb begin
        cfg      = decode_edge(pol_np, pol_p, encoder_mode);
        prev_d   = tin;
        rise     = tin & ~prev_q;
        fall     = ~tin & prev_q;
        edge_evt = 1'b0;
        if (in_mode) begin
            unique case (cfg.mode)
                EDGE_RISE: edge_evt = rise;
                EDGE_FALL: edge_evt = fall;
                EDGE_BOTH: edge_evt = rise | fall;
                default:   edge_evt = rise;
            endcase
        end
        lvl_out  = in_mode & (tin ^ cfg.invert);
        code_err = in_mode & cfg.bad_code;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assert_no_evt_out_R12: assert property (@(posedge clk) disable iff (rst)
        !in_mode |-> (!edge_evt && !lvl_out));
    assert_rise_only_R1: assert property (@(posedge clk) disable iff (rst)
        (in_mode && {pol_np, pol_p} == 2'b00 && edge_evt) |-> (tin && !prev_q));
    assert_fall_only_R2: assert property (@(posedge clk) disable iff (rst)
        (in_mode && {pol_np, pol_p} == 2'b01 && edge_evt) |-> (!tin && prev_q));
    assert_enc_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (in_mode && {pol_np, pol_p} == 2'b11 && encoder_mode && edge_evt) |-> tin);
    assert_reserved_err_R4: assert property (@(posedge clk) disable iff (rst)
        (in_mode && {pol_np, pol_p} == 2'b10) |-> code_err);

endmodule

// File: rtl/chanfe_capture.sv
module chanfe_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);

    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
        logic             ovr;
    } cap_st_t;

    cap_st_t st_d, st_q;
    logic    take;

    always_comb begin
        take = evt & cap_en;
        st_d = st_q;
        if (flag_clr) begin
            st_d.flag = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (take) begin
            st_d.cap  = cnt_val;
            st_d.flag = 1'b1;
            if (st_q.flag && !flag_clr) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cap_val  = st_q.cap;
    assign cap_flag = st_q.flag;
    assign ovr_flag = st_q.ovr;

    assert_cap_load_R6: assert property (@(posedge clk) disable iff (rst)
        (evt && cap_en) |=> (cap_val == $past(cnt_val)) && cap_flag);
    assert_cap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(evt && cap_en) |=> $stable(cap_val));
    assert_flag_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(evt && cap_en)) |=> (!cap_flag && !ovr_flag));
    assert_ovr_set_R8: assert property (@(posedge clk) disable iff (rst)
        (evt && cap_en && cap_flag && !flag_clr) |=> ovr_flag);
    assert_ovr_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        ovr_flag |-> cap_flag);

endmodule

// File: rtl/chanfe_out_gate.sv
module chanfe_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic out_mode,
    input  logic out_en,
    input  logic pol_p,
    input  logic pol_np,
    input  logic oc_ref,
    output logic pin_val,
    output logic pin_oe,
    output logic np_err
);

    typedef struct packed {
        logic val;
        logic oe;
    } pin_st_t;

    pin_st_t pin_d, pin_q;

    always_comb begin
        pin_d = '0;
        if (out_mode && out_en) begin
            pin_d.oe  = 1'b1;
            pin_d.val = oc_ref ^ pol_p;
        end
        np_err = out_mode & pol_np;
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_d;
    end

    assign pin_val = pin_q.val;
    assign pin_oe  = pin_q.oe;

    assert_pin_off_R9: assert property (@(posedge clk) disable iff (rst)
        !(out_mode && out_en) |=> (!pin_oe && !pin_val));
    assert_pin_on_R10: assert property (@(posedge clk) disable iff (rst)
        (out_mode && out_en) |=> (pin_oe && pin_val == $past(oc_ref ^ pol_p)));
    assert_np_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (out_mode && pol_np) |-> np_err);

endmodule

// File: rtl/timer_chan_frontend.sv
module timer_chan_frontend #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_out,
    input  logic             pol_p,
    input  logic             pol_np,
    input  logic             chan_en,
    input  logic             encoder_mode,
    input  logic             tin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             oc_ref,
    input  logic             flag_clr,
    output logic             edge_evt,
    output logic             lvl_out,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag,
    output logic             pin_val,
    output logic             pin_oe,
    output logic             cfg_err
);

    logic in_mode;
    logic in_err, out_err;

    assign in_mode = ~dir_out;

    chanfe_edge_qual u_edge (
        .clk          (clk),
        .rst          (rst),
        .in_mode      (in_mode),
        .pol_p        (pol_p),
        .pol_np       (pol_np),
        .encoder_mode (encoder_mode),
        .tin          (tin),
        .edge_evt     (edge_evt),
        .lvl_out      (lvl_out),
        .code_err     (in_err)
    );

    chanfe_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .evt      (edge_evt),
        .cap_en   (chan_en),
        .cnt_val  (cnt_val),
        .flag_clr (flag_clr),
        .cap_val  (cap_val),
        .cap_flag (cap_flag),
        .ovr_flag (ovr_flag)
    );

    chanfe_out_gate u_out (
        .clk      (clk),
        .rst      (rst),
        .out_mode (dir_out),
        .out_en   (chan_en),
        .pol_p    (pol_p),
        .pol_np   (pol_np),
        .oc_ref   (oc_ref),
        .pin_val  (pin_val),
        .pin_oe   (pin_oe),
        .np_err   (out_err)
    );

    assign cfg_err = in_err | out_err;

    assert_err_mode_R11: assert property (@(posedge clk) disable iff (rst)
        (dir_out && !pol_np) |-> !cfg_err);
    assert_both_ok_R3: assert property (@(posedge clk) disable iff (rst)
        (!dir_out && pol_np && pol_p && !encoder_mode) |-> !cfg_err);

endmodule

// File: tb/tb_timer_chan_frontend.sv
module tb_timer_chan_frontend;

    localparam int CNT_W  = 8;
    localparam int CLK_PD = 10;

    logic             clk = 1'b0;
    logic             rst, dir_out, pol_p, pol_np, chan_en, encoder_mode, tin, oc_ref, flag_clr;
    logic [CNT_W-1:0] cnt_val;
    logic             edge_evt, lvl_out, cap_flag, ovr_flag, pin_val, pin_oe, cfg_err;
    logic [CNT_W-1:0] cap_val;

    int n_chk = 0;
    int n_bad = 0;

    logic             m_prev, m_flag, m_ovr, m_pv, m_oe;
    logic [CNT_W-1:0] m_cap;

    always #(CLK_PD/2) clk = ~clk;

    timer_chan_frontend #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .dir_out(dir_out), .pol_p(pol_p), .pol_np(pol_np),
        .chan_en(chan_en), .encoder_mode(encoder_mode), .tin(tin), .cnt_val(cnt_val),
        .oc_ref(oc_ref), .flag_clr(flag_clr), .edge_evt(edge_evt), .lvl_out(lvl_out),
        .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag), .pin_val(pin_val),
        .pin_oe(pin_oe), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string in_tag(input logic np, input logic p, input logic enc);
        case ({np, p})
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R4";
            default: return enc ? "R5" : "R3";
        endcase
    endfunction

    // one clock: drive at falling edge, check combinational outputs, then registered ones
    task automatic cycle(input logic d, input logic np, input logic p, input logic en,
                         input logic enc, input logic t, input logic [CNT_W-1:0] cv,
                         input logic r, input logic clr);
        logic  e_evt, e_lvl, e_err, rise, fall;
        string tg;
        dir_out = d; pol_np = np; pol_p = p; chan_en = en; encoder_mode = enc;
        tin = t; cnt_val = cv; oc_ref = r; flag_clr = clr;
        #1;
        rise = t & ~m_prev;
        fall = ~t & m_prev;
        if (d) begin
            e_evt = 1'b0; e_lvl = 1'b0; e_err = np; tg = "R11";
        end else begin
            tg = in_tag(np, p, enc);
            e_err = ({np, p} == 2'b10) || ({np, p} == 2'b11 && enc);
            if ({np, p} == 2'b01) begin
                e_evt = fall; e_lvl = ~t;
            end else if ({np, p} == 2'b11 && !enc) begin
                e_evt = rise | fall; e_lvl = t;
            end else begin
                e_evt = rise; e_lvl = t;
            end
        end
        chk(d ? "R12" : tg, "edge_evt", int'(edge_evt), int'(e_evt));
        chk(d ? "R12" : tg, "lvl_out", int'(lvl_out), int'(e_lvl));
        chk(tg, "cfg_err", int'(cfg_err), int'(e_err));
        @(posedge clk);
        if (clr) begin m_flag = 1'b0; m_ovr = 1'b0; end
        if (e_evt && en) begin
            if (m_flag) m_ovr = 1'b1;
            m_cap = cv; m_flag = 1'b1;
        end
        m_prev = t;
        m_oe = d & en;
        m_pv = d & en & (r ^ p);
        @(negedge clk);
        chk("R6", "cap_val", int'(cap_val), int'(m_cap));
        chk("R7", "cap_flag", int'(cap_flag), int'(m_flag));
        chk("R8", "ovr_flag", int'(ovr_flag), int'(m_ovr));
        chk(m_oe ? "R10" : "R9", "pin_oe", int'(pin_oe), int'(m_oe));
        chk(m_oe ? "R10" : "R9", "pin_val", int'(pin_val), int'(m_pv));
    endtask

    task automatic do_reset();
        rst = 1'b1; dir_out = 1'b1; chan_en = 1'b1; oc_ref = 1'b1; tin = 1'b1;
        pol_p = 1'b0; pol_np = 1'b0; encoder_mode = 1'b0; flag_clr = 1'b0; cnt_val = '1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_prev = 1'b0; m_flag = 1'b0; m_ovr = 1'b0; m_cap = '0; m_pv = 1'b0; m_oe = 1'b0;
        chk("R12", "reset cap_val", int'(cap_val), 0);
        chk("R12", "reset cap_flag", int'(cap_flag), 0);
        chk("R12", "reset ovr_flag", int'(ovr_flag), 0);
        chk("R12", "reset pin_oe", int'(pin_oe), 0);
        chk("R12", "reset pin_val", int'(pin_val), 0);
    endtask

    initial begin : watchdog
        #(CLK_PD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        int k;
        do_reset();
        // reset left prev sample at 0: first input cycle with tin=1 is a rising edge (R12)
        k = 0;
        for (int d = 0; d < 2; d++)
            for (int code = 0; code < 4; code++)
                for (int enc = 0; enc < 2; enc++)
                    for (int en = 0; en < 2; en++)
                        for (int a = 0; a < 2; a++)
                            for (int b = 0; b < 2; b++)
                                for (int r = 0; r < 2; r++) begin
                                    k++;
                                    cycle(d[0], code[1], code[0], en[0], enc[0], a[0],
                                          CNT_W'(k * 3), r[0], 1'b0);
                                    cycle(d[0], code[1], code[0], en[0], enc[0], b[0],
                                          CNT_W'(k * 7 + 1), ~r[0], (k % 5) == 0);
                                end
        // directed: capture and clear in the same cycle keep the flag (R7)
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd10, 1'b0, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd20, 1'b0, 1'b1);
        chk("R7", "flag after capture+clear", int'(cap_flag), 1);
        chk("R8", "no ovr on capture+clear", int'(ovr_flag), 0);
        // second capture without clear raises overcapture (R8)
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd30, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd40, 1'b0, 1'b0);
        chk("R8", "ovr after second capture", int'(ovr_flag), 1);
        chk("R6", "cap_val second capture", int'(cap_val), 40);
        // mid-run reset clears everything (R12)
        do_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule